// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the receive half of a synthesizable NAND flash device model. On every clock in which the write strobe `we` is high, it samples the shared I/O bus. It then decides from chip enable, the command latch pin and the address latch pin whether the cycle carries a command byte, an address byte or data. Data cycles are left to other logic. Command bytes update the current command and, for some opcodes, the column offset. Address bytes are assembled, least significant byte first, into a 40-bit address register.

The block also decides when an operation may begin. Some commands start at once, read ID starts after one address byte, and reads and program loads start after a number of address bytes that depends on the device class. Each start is a single-cycle strobe on the `go` vector. That strobe appears in the clock after the bus cycle that caused it, and the command, column, row and offset outputs are updated at the same time. The device class, the bus width and the page size are parameters.

Top module: `nfl_cmd_front`

## Requirements
- R1: A write cycle (`we` high) counts as a command only if `ce_n` is low and `cle` is high. It counts as an address byte only if `ce_n` is low, `cle` is low and `ale` is high. Cycles with `ce_n` high, cycles with `we` low and data cycles (`cle` and `ale` both low) change no output and raise no strobe.
- R2: Address byte n (counted from 0 since the last command byte) replaces bits [8n+7:8n] of a 40-bit address register. Bytes after the fifth are dropped. On a small-page device the column is bits [7:0] and the row is bits [31:8]. On a large-page device the column is bits [15:0] and the row is bits [39:16].
- R3: A command byte restarts the address byte count at zero and leaves the address register as it was, so the next address byte replaces bits [7:0].
- R4: On a small-page device, 0x01 sets the column offset to 256 and 0x50 sets it to the page size, and both leave the current command at 0x00. 0x00 clears the offset. On a large-page device these opcodes are latched as they are and the offset stays 0.
- R5: On a large-page device, 0x30 raises the read strobe when the current command is 0x00. 0x05 clears the column field and keeps the row.
- R6: Some opcodes raise their strobe at once: 0x70 gives status, 0x10 and 0x15 give program, and 0xD0 gives erase. On large-page devices, 0x35 and 0xE0 give read. 0x60 only latches.
- R7: After 0x90, the first address byte raises the ID strobe. Later bytes do not raise it again.
- R8: The start threshold is 3 address bytes on a small-page device, 4 on a large-page device of 1 Gbit or less, and 5 on a large-page device of 2 Gbit or more. The byte that reaches it raises the read strobe (small-page read, command 0x00) or the load strobe (command 0x80).
- R9: With a 16-bit bus, the whole address register shifts left by one bit right after the second address byte is stored.
- R10: 0xFF raises the reset strobe, sets the current command to 0x00 and clears the column offset.
- R11: `wr_unlocked` equals `wp_n` one clock later.
- R12: `go` bits are read 0, load 1, program 2, erase 3, ID 4, status 5, reset 6. At most one bit is high in any cycle, and a bit is high only in the cycle after an enabled write.
- R13: While `rst_n` is low at a clock edge, the current command is 0x00, the address, count and offset are zero, and `go` and `wr_unlocked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we | input | 1 | Bus write strobe, one sample per high cycle |
| wp_n | input | 1 | Write protect, active low |
| io | input | IO_W | Shared bus; the low byte carries commands and addresses |
| cur_cmd | output | 8 | Current command |
| col_addr | output | 16 | Column field of the address register |
| row_addr | output | 24 | Row field of the address register |
| col_off | output | OFF_W | Column offset chosen by legacy read opcodes |
| go | output | GO_N (7) | One-hot operation start strobes |
| wr_unlocked | output | 1 | Registered copy of `wp_n` |

## Verification
Most wrong internal states become visible one clock after the next enabled write. A wrong current command shows up on `cur_cmd` at once. A wrong address byte count stays hidden until the next address byte, and then either puts that byte in the wrong place in `col_addr`/`row_addr` or moves the read, load or ID strobe by a cycle. A wrong offset or a missed 16-bit shift shows on `col_off` or `col_addr` straight after the opcode or the second address byte. Three device variants run the same stimulus, so every threshold and width branch can be compared each cycle against a behavioural model.

// File: rtl/nfl_pkg.sv
// Shared opcodes, strobe indices and the bus-cycle type for the NAND
// command/address front end. Assumes opcodes travel on the low byte.
package nfl_pkg;

    localparam logic [7:0] OPC_READ       = 8'h00;
    localparam logic [7:0] OPC_READ_HI    = 8'h01;
    localparam logic [7:0] OPC_READ_SPARE = 8'h50;
    localparam logic [7:0] OPC_READ_GO    = 8'h30;
    localparam logic [7:0] OPC_READ_NS    = 8'h35;
    localparam logic [7:0] OPC_RAND_SET   = 8'h05;
    localparam logic [7:0] OPC_RAND_GO    = 8'hE0;
    localparam logic [7:0] OPC_IDENT      = 8'h90;
    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_PROG_SET   = 8'h80;
    localparam logic [7:0] OPC_PROG_GO    = 8'h10;
    localparam logic [7:0] OPC_PROG_CACHE = 8'h15;
    localparam logic [7:0] OPC_ERASE_SET  = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OPC_STATUS     = 8'h70;
    localparam logic [7:0] OPC_COPY_SET   = 8'h85;

    localparam int GO_READ   = 0;
    localparam int GO_LOAD   = 1;
    localparam int GO_PROG   = 2;
    localparam int GO_ERASE  = 3;
    localparam int GO_ID     = 4;
    localparam int GO_STATUS = 5;
    localparam int GO_RESET  = 6;
    localparam int GO_N      = 7;

    // One classified bus cycle: command flag, address flag, low byte.
    typedef struct packed {
        logic       cmd;
        logic       adr;
        logic [7:0] val;
    } bus_cyc_t;

endpackage

// File: rtl/nfl_bus_classify.sv
// Classifies a sampled bus cycle as command, address or neither.
// Assumes one sample per clock while we is high; cle wins over ale.
module nfl_bus_classify #(
    parameter int IO_W = 8
) (
    input  logic            we,
    input  logic            ce_n,
    input  logic            cle,
    input  logic            ale,
    input  logic [IO_W-1:0] io,
    output nfl_pkg::bus_cyc_t cyc
);

    // Qualify the strobe with the latch pins and forward the low byte.
    always_comb begin
        cyc.cmd = we && !ce_n && cle;
        cyc.adr = we && !ce_n && !cle && ale;
        cyc.val = io[7:0];
    end

endmodule

// File: rtl/nfl_cmd_decode.sv
// Holds the current command and column offset; produces the strobes of
// commands that start at once and the column-clear request.
// Assumes LARGE_PAGE is fixed at build time.
module nfl_cmd_decode
    import nfl_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b0,
    parameter int PAGE_BYTES = 512,
    parameter int OFF_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_cyc_t         cyc,
    output logic [7:0]       cmd_q,
    output logic [OFF_W-1:0] off_q,
    output logic [GO_N-1:0]  imm_go,
    output logic             col_clr
);

    localparam logic [OFF_W-1:0] OFF_HALF  = OFF_W'(256);
    localparam logic [OFF_W-1:0] OFF_SPARE = OFF_W'(PAGE_BYTES);

    logic [7:0]       cmd_n;
    logic [OFF_W-1:0] off_n;

    // Decode a command byte into the next command, offset and strobes.
    always_comb begin
        cmd_n   = cmd_q;
        off_n   = off_q;
        imm_go  = '0;
        col_clr = 1'b0;
        if (cyc.cmd) begin
            cmd_n = cyc.val;
            if (!LARGE_PAGE) begin
                if (cyc.val == OPC_READ) begin
                    off_n = '0;
                end else if (cyc.val == OPC_READ_HI) begin
                    off_n = OFF_HALF;
                    cmd_n = OPC_READ;
                end else if (cyc.val == OPC_READ_SPARE) begin
                    off_n = OFF_SPARE;
                    cmd_n = OPC_READ;
                end
            end else begin
                if (cyc.val == OPC_READ_GO && cmd_q == OPC_READ)
                    imm_go[GO_READ] = 1'b1;
                if (cyc.val == OPC_READ_NS || cyc.val == OPC_RAND_GO)
                    imm_go[GO_READ] = 1'b1;
                if (cyc.val == OPC_RAND_SET)
                    col_clr = 1'b1;
            end
            case (cyc.val)
                OPC_STATUS:                  imm_go[GO_STATUS] = 1'b1;
                OPC_PROG_GO, OPC_PROG_CACHE: imm_go[GO_PROG]   = 1'b1;
                OPC_ERASE_GO:                imm_go[GO_ERASE]  = 1'b1;
                OPC_RESET: begin
                    imm_go[GO_RESET] = 1'b1;
                    cmd_n            = OPC_READ;
                    off_n            = '0;
                end
                default: ;
            endcase
        end
    end

    // Register the command and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= OPC_READ;
            off_q <= '0;
        end else begin
            cmd_q <= cmd_n;
            off_q <= off_n;
        end
    end

endmodule

// File: rtl/nfl_addr_build.sv
// Assembles address bytes little-endian and counts them since the last
// command. Assumes the count saturates well above any start threshold.
module nfl_addr_build
    import nfl_pkg::*;
#(
    parameter bit IO16    = 1'b0,
    parameter int CYC_MAX = 5,
    parameter int COL_W   = 8,
    parameter int ADDR_W  = 8 * CYC_MAX,
    parameter int CNT_W   = $clog2(CYC_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cyc_t          cyc,
    input  logic              col_clr,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [ADDR_W-1:0] addr_n;
    logic [CNT_W-1:0]  cnt_n;

    // Place the incoming byte, apply the 16-bit shift, advance the count.
    always_comb begin
        addr_n = addr_q;
        cnt_n  = cnt_q;
        if (cyc.cmd) begin
            cnt_n = '0;
            if (col_clr)
                addr_n[COL_W-1:0] = '0;
        end else if (cyc.adr) begin
            for (int i = 0; i < CYC_MAX; i++) begin
                if (cnt_q == CNT_W'(i))
                    addr_n[8*i +: 8] = cyc.val;
            end
            if (IO16 && cnt_q == CNT_W'(1))
                addr_n = addr_n << 1;
            if (cnt_q != CNT_TOP)
                cnt_n = cnt_q + 1'b1;
        end
    end

    // Register address and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_n;
            cnt_q  <= cnt_n;
        end
    end

endmodule

// File: rtl/nfl_cmd_front.sv
// NAND command/address front end: classifies bus cycles, tracks the
// command, builds the address and issues one-cycle start strobes.
// Assumes commands and addresses use the low byte of io.
module nfl_cmd_front
    import nfl_pkg::*;
#(
    parameter int IO_W         = 8,
    parameter bit LARGE_PAGE   = 1'b0,
    parameter bit HIGH_DENSITY = 1'b0,
    parameter int PAGE_BYTES   = 512,
    parameter int OFF_W        = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we,
    input  logic             wp_n,
    input  logic [IO_W-1:0]  io,
    output logic [7:0]       cur_cmd,
    output logic [15:0]      col_addr,
    output logic [23:0]      row_addr,
    output logic [OFF_W-1:0] col_off,
    output logic [GO_N-1:0]  go,
    output logic             wr_unlocked
);

    localparam int CYC_MAX = 5;
    localparam int ADDR_W  = 8 * CYC_MAX;
    localparam int CNT_W   = $clog2(CYC_MAX + 2);
    localparam int COL_W   = LARGE_PAGE ? 16 : 8;
    localparam int N_RW    = !LARGE_PAGE ? 3 : (HIGH_DENSITY ? 5 : 4);
    localparam bit IO16    = (IO_W == 16);

    bus_cyc_t          cyc;
    logic [7:0]        cmd_q;
    logic [GO_N-1:0]   imm_go;
    logic              col_clr;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [GO_N-1:0]   go_n;
    logic [GO_N-1:0]   go_q;
    logic              wr_q;

    nfl_bus_classify #(.IO_W(IO_W)) u_class (
        .we(we), .ce_n(ce_n), .cle(cle), .ale(ale), .io(io), .cyc(cyc)
    );

    nfl_cmd_decode #(
        .LARGE_PAGE(LARGE_PAGE), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .cmd_q(cmd_q),
        .off_q(col_off), .imm_go(imm_go), .col_clr(col_clr)
    );

    nfl_addr_build #(
        .IO16(IO16), .CYC_MAX(CYC_MAX), .COL_W(COL_W),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .col_clr(col_clr),
        .addr_q(addr_q), .cnt_q(cnt_q)
    );

    // Merge immediate strobes with those triggered by address counts.
    always_comb begin
        go_n = imm_go;
        if (cyc.adr && cnt_q == '0 && cmd_q == OPC_IDENT)
            go_n[GO_ID] = 1'b1;
        if (cyc.adr && cnt_q == CNT_W'(N_RW - 1)) begin
            if (cmd_q == OPC_READ && !LARGE_PAGE)
                go_n[GO_READ] = 1'b1;
            if (cmd_q == OPC_PROG_SET)
                go_n[GO_LOAD] = 1'b1;
        end
    end

    // Register the strobes and the write-protect state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q <= '0;
            wr_q <= 1'b0;
        end else begin
            go_q <= go_n;
            wr_q <= wp_n;
        end
    end

    // Split the address register into column and row by page class.
    generate
        if (LARGE_PAGE) begin : g_large
            assign col_addr = addr_q[15:0];
            assign row_addr = addr_q[39:16];
        end else begin : g_small
            assign col_addr = {8'h00, addr_q[7:0]};
            assign row_addr = addr_q[31:8];
        end
    endgenerate

    assign cur_cmd     = cmd_q;
    assign go          = go_q;
    assign wr_unlocked = wr_q;

endmodule

// File: rtl/nfl_cmd_front_chk.sv
// Port-level properties for nfl_cmd_front, attached by bind below.
module nfl_cmd_front_chk
    import nfl_pkg::*;
#(
    parameter int IO_W  = 8,
    parameter int OFF_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             cle,
    input logic             we,
    input logic             wp_n,
    input logic [IO_W-1:0]  io,
    input logic [7:0]       cur_cmd,
    input logic [OFF_W-1:0] col_off,
    input logic [GO_N-1:0]  go,
    input logic             wr_unlocked
);

    // R12
    go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go));

    // R12
    go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go != '0) |-> $past(we && !ce_n));

    // R1
    ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ce_n) |=> (go == '0) && $stable(cur_cmd) && $stable(col_off));

    // R10
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ce_n && cle && io[7:0] == 8'hFF)
        |=> (cur_cmd == 8'h00) && (col_off == '0) && go[GO_RESET]);

    // R6
    status_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ce_n && cle && io[7:0] == 8'h70) |=> go[GO_STATUS]);

    // R11
    wp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_unlocked == $past(wp_n)));

endmodule

bind nfl_cmd_front nfl_cmd_front_chk #(.IO_W(IO_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .we(we),
    .wp_n(wp_n), .io(io), .cur_cmd(cur_cmd), .col_off(col_off),
    .go(go), .wr_unlocked(wr_unlocked)
);

// File: tb/tb_nfl_cmd_front.sv
`timescale 1ns/1ps
module tb_nfl_cmd_front;
    import nfl_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we = 1'b0, wp_n = 1'b1;
    logic [15:0] io = '0;

    logic [7:0]      cmd_o [3];
    logic [15:0]     col_o [3];
    logic [23:0]     row_o [3];
    logic [GO_N-1:0] go_o  [3];
    logic            wr_o  [3];
    logic [9:0]      off0;
    logic [11:0]     off1, off2;

    // Small page, 8-bit bus, 3 address bytes
    nfl_cmd_front #(.IO_W(8), .LARGE_PAGE(1'b0), .HIGH_DENSITY(1'b0), .PAGE_BYTES(512)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n),
        .io(io[7:0]), .cur_cmd(cmd_o[0]), .col_addr(col_o[0]), .row_addr(row_o[0]),
        .col_off(off0), .go(go_o[0]), .wr_unlocked(wr_o[0]));
    // Large page, 16-bit bus, 5 address bytes
    nfl_cmd_front #(.IO_W(16), .LARGE_PAGE(1'b1), .HIGH_DENSITY(1'b1), .PAGE_BYTES(2048)) dut_lp (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n),
        .io(io), .cur_cmd(cmd_o[1]), .col_addr(col_o[1]), .row_addr(row_o[1]),
        .col_off(off1), .go(go_o[1]), .wr_unlocked(wr_o[1]));
    // Large page, 8-bit bus, 4 address bytes
    nfl_cmd_front #(.IO_W(8), .LARGE_PAGE(1'b1), .HIGH_DENSITY(1'b0), .PAGE_BYTES(2048)) dut_mid (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n),
        .io(io[7:0]), .cur_cmd(cmd_o[2]), .col_addr(col_o[2]), .row_addr(row_o[2]),
        .col_off(off2), .go(go_o[2]), .wr_unlocked(wr_o[2]));

    // Reference model state, one set per device variant
    int          c_lp  [3] = '{0, 1, 1};
    int          c_big [3] = '{0, 1, 0};
    int          c_w16 [3] = '{0, 1, 0};
    int          c_pg  [3] = '{512, 2048, 2048};
    int          m_cmd [3], m_off [3], m_cnt [3], m_go [3], m_wr [3];
    logic [39:0] m_addr [3];

    int    vectors = 0;
    int    fails   = 0;
    bit    armed   = 0;
    string cur_req = "R13";

    function automatic int thresh(int k);
        if (c_lp[k] == 0) return 3;
        return (c_big[k] != 0) ? 5 : 4;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int off_of(int k);
        if (k == 0) return int'(off0);
        if (k == 1) return int'(off1);
        return int'(off2);
    endfunction

    task automatic check_all();
        for (int k = 0; k < 3; k++) begin
            cmp(cur_req, $sformatf("dev%0d cmd", k), int'(cmd_o[k]), m_cmd[k]);
            cmp(cur_req, $sformatf("dev%0d col", k), int'(col_o[k]),
                c_lp[k] != 0 ? int'(m_addr[k][15:0]) : int'(m_addr[k][7:0]));
            cmp(cur_req, $sformatf("dev%0d row", k), int'(row_o[k]),
                c_lp[k] != 0 ? int'(m_addr[k][39:16]) : int'(m_addr[k][31:8]));
            cmp(cur_req, $sformatf("dev%0d off", k), off_of(k), m_off[k]);
            cmp(cur_req, $sformatf("dev%0d go", k), int'(go_o[k]), m_go[k]);
            cmp(cur_req, $sformatf("dev%0d wr", k), int'(wr_o[k]), m_wr[k]);
        end
    endtask

    task automatic model_step(int k);
        int b;
        b = int'(io[7:0]);
        m_go[k] = 0;
        if (!rst_n) begin
            m_cmd[k] = 0; m_off[k] = 0; m_addr[k] = '0; m_cnt[k] = 0; m_wr[k] = 0;
            return;
        end
        m_wr[k] = int'(wp_n);
        if (we && !ce_n && cle) begin
            m_cnt[k] = 0;
            if (b == 'hFF) begin
                m_cmd[k] = 0; m_off[k] = 0; m_go[k] = 1 << 6;
            end else begin
                if (c_lp[k] != 0) begin
                    if (b == 'h30 && m_cmd[k] == 0) m_go[k] = 1;
                    if (b == 'h35 || b == 'hE0) m_go[k] = 1;
                    if (b == 'h05) m_addr[k][15:0] = '0;
                    m_cmd[k] = b;
                end else begin
                    if (b == 'h01) begin m_off[k] = 256; m_cmd[k] = 0; end
                    else if (b == 'h50) begin m_off[k] = c_pg[k]; m_cmd[k] = 0; end
                    else begin
                        if (b == 0) m_off[k] = 0;
                        m_cmd[k] = b;
                    end
                end
                if (b == 'h70) m_go[k] = 1 << 5;
                if (b == 'h10 || b == 'h15) m_go[k] = 1 << 2;
                if (b == 'hD0) m_go[k] = 1 << 3;
            end
        end else if (we && !ce_n && ale) begin
            if (m_cnt[k] < 5) m_addr[k][8*m_cnt[k] +: 8] = io[7:0];
            if (c_w16[k] != 0 && m_cnt[k] == 1) m_addr[k] = m_addr[k] << 1;
            if (m_cnt[k] < 7) m_cnt[k]++;
            if (m_cmd[k] == 'h90 && m_cnt[k] == 1) m_go[k] = 1 << 4;
            if (m_cnt[k] == thresh(k)) begin
                if (m_cmd[k] == 0 && c_lp[k] == 0) m_go[k] = 1;
                if (m_cmd[k] == 'h80) m_go[k] = 2;
            end
        end
    endtask

    // One bus cycle: compare at the falling edge, drive, advance the model.
    task automatic cyc(logic r, logic e_n, logic c, logic a, logic w, logic [15:0] d, logic p);
        @(negedge clk);
        if (armed) check_all();
        rst_n = r; ce_n = e_n; cle = c; ale = a; we = w; io = d; wp_n = p;
        for (int k = 0; k < 3; k++) model_step(k);
        if (!r) armed = 1;
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, wp_n);
    endtask
    task automatic cmdb(logic [7:0] b);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, {8'h00, b}, wp_n); idle();
    endtask
    task automatic addrb(logic [7:0] b);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, {8'h00, b}, wp_n); idle();
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R13 reset state
        cur_req = "R13";
        repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
        idle();
        cmp("R13", "cmd after reset", int'(cmd_o[0]), 0);
        cmp("R13", "go after reset", int'(go_o[1]), 0);
        cmp("R13", "row after reset", int'(row_o[2]), 0);

        // R1 disabled chip, strobe low, data cycle
        cur_req = "R1";
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0070, 1'b1); idle();
        cmp("R1", "go with ce_n high", int'(go_o[0]), 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0070, 1'b1); idle();
        cmp("R1", "go with we low", int'(go_o[0]), 0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0055, 1'b1); idle();
        cmp("R1", "cmd after data cycle", int'(cmd_o[0]), 0);
        cmp("R1", "col after data cycle", int'(col_o[0]), 0);

        // R2 little-endian assembly and column/row split
        cur_req = "R2";
        cmdb(8'h00); addrb(8'h12); addrb(8'h34); addrb(8'h56);
        cmp("R2", "small col", int'(col_o[0]), 'h12);
        cmp("R2", "small row", int'(row_o[0]), 'h5634);
        cmp("R8", "small read strobe at 3rd byte", int'(go_o[0]), 1);
        cmp("R2", "large col", int'(col_o[2]), 'h3412);
        cmp("R2", "large row", int'(row_o[2]), 'h56);
        addrb(8'h78);
        cmp("R2", "small row after 4th byte", int'(row_o[0]), 'h785634);

        // R5 large-page confirm and column clear
        cur_req = "R5";
        cmdb(8'h30);
        cmp("R5", "large read confirm", int'(go_o[2]), 1);
        cmp("R5", "small ignores 0x30", int'(go_o[0]), 0);
        cmdb(8'h05);
        cmp("R5", "column cleared", int'(col_o[2]), 0);
        cmp("R5", "row kept", int'(row_o[2]), 'h7856);
        addrb(8'h10); addrb(8'h00);
        cmp("R5", "new column", int'(col_o[2]), 'h0010);
        cmp("R9", "16-bit column shifted", int'(col_o[1]), 'h0020);
        cmdb(8'hE0);
        cmp("R6", "random output start", int'(go_o[1]), 1);

        // R4 small-page offset opcodes
        cur_req = "R4";
        cmdb(8'h01);
        cmp("R4", "offset half", off_of(0), 256);
        cmp("R4", "cmd folded to read", int'(cmd_o[0]), 0);
        cmdb(8'h50);
        cmp("R4", "offset spare", off_of(0), 512);
        cmp("R4", "large keeps 0x50", int'(cmd_o[1]), 'h50);
        cmp("R4", "large offset zero", off_of(1), 0);
        cmdb(8'h00);
        cmp("R4", "offset cleared", off_of(0), 0);

        // R8 thresholds by device class
        cur_req = "R8";
        cmdb(8'h80); addrb(8'h01); addrb(8'h02); addrb(8'h03);
        cmp("R8", "small load at 3", int'(go_o[0]), 2);
        cmp("R8", "mid none at 3", int'(go_o[2]), 0);
        addrb(8'h04);
        cmp("R8", "mid load at 4", int'(go_o[2]), 2);
        cmp("R8", "large none at 4", int'(go_o[1]), 0);
        addrb(8'h05);
        cmp("R8", "large load at 5", int'(go_o[1]), 2);
        addrb(8'h06); addrb(8'h07);

        // R9 16-bit shift on a fresh read address
        cur_req = "R9";
        cmdb(8'h00); addrb(8'h11); addrb(8'h22);
        cmp("R9", "byte column", int'(col_o[1]), 'h4422);

        // R3 command restarts count, keeps bytes
        cur_req = "R3";
        cmdb(8'h80); addrb(8'hAA); addrb(8'hBB); cmdb(8'h80); addrb(8'hCC);
        cmp("R3", "byte 0 replaced", int'(col_o[0]), 'hCC);
        cmp("R3", "byte 1 kept", int'(row_o[0]) & 'hFF, 'hBB);

        // R6 immediate commands
        cur_req = "R6";
        cmdb(8'h70); cmp("R6", "status", int'(go_o[0]), 'h20);
        cmdb(8'h10); cmp("R6", "program", int'(go_o[0]), 'h04);
        cmdb(8'h15); cmp("R6", "cache program", int'(go_o[2]), 'h04);
        cmdb(8'h60); cmp("R6", "erase setup silent", int'(go_o[0]), 0);
        addrb(8'h01); addrb(8'h02);
        cmdb(8'hD0); cmp("R6", "erase", int'(go_o[0]), 'h08);
        cmdb(8'h35);
        cmp("R6", "no-serial read large", int'(go_o[1]), 1);
        cmp("R6", "no-serial read small", int'(go_o[0]), 0);

        // R7 read ID
        cur_req = "R7";
        cmdb(8'h90); addrb(8'h00);
        cmp("R7", "id strobe", int'(go_o[0]), 'h10);
        addrb(8'h00);
        cmp("R7", "id once", int'(go_o[0]), 0);

        // R10 reset command
        cur_req = "R10";
        cmdb(8'h50); cmdb(8'hFF);
        cmp("R10", "cmd to read", int'(cmd_o[0]), 0);
        cmp("R10", "offset cleared", off_of(0), 0);
        cmp("R10", "reset strobe", int'(go_o[0]), 'h40);

        // R11 write protect tracking
        cur_req = "R11";
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0); idle();
        cmp("R11", "locked", int'(wr_o[0]), 0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1); idle();
        cmp("R11", "unlocked", int'(wr_o[1]), 1);

        // R12 strobe encoding over a mixed burst, compared by the model
        cur_req = "R12";
        cmdb(8'h80); addrb(8'h09); cmdb(8'h70); addrb(8'h01); cmdb(8'h90);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0003, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0010, 1'b1);
        idle();
        cmp("R12", "last strobe program", int'(go_o[2]), 'h04);

        // R13 reset mid-run
        cur_req = "R13";
        cmdb(8'h50);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1); idle();
        cmp("R13", "offset after reset", off_of(0), 0);
        cmp("R13", "col after reset", int'(col_o[1]), 0);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule